// File: doc/BRIEF.md
# Delay-Line Phase Search Controller

This block drives the tap select of a tapped delay line so that the clock phase reported by a phase detector settles on a programmed target. The target is a small signed number. After a reset or enable, the controller starts from a programmed tap near the middle of the line. It sweeps the line until the reported phase is acceptable, and from then on it either holds that tap or keeps correcting it. A guard band keeps the first sweep away from both ends of the line. The ends are only visited when the middle holds no acceptable tap.

Each decision is made on an evaluation tick, one every `EVAL_CYC` clocks, so the analog path has time to settle between tap moves. Software can sample the present tap and phase without tearing by pulsing a read-request line. When the controller is disabled, the tap follows a manual value instead.

Top module: `phs_search_ctrl`

## Requirements
- R1: While `cfg_en` is 0, `tap_out` equals `cfg_manual` clamped to 432, and `locked` and `lost_lock` are 0, all one clock after the sample. After reset, all outputs are 0.
- R2: On the first enabled clock, the tap loads `cfg_start` clamped to 432. After that, the tap changes only on an evaluation tick, and ticks come every `EVAL_CYC` (default 4) clocks, the first on the `EVAL_CYC`-th clock after leaving idle.
- R3: `cfg_mode` selects the operation: 0 is search then track, 1 is track only, 2 is search only (the tap is frozen after lock), and 3 keeps the tap at the start tap with no lock.
- R4: `cfg_dir` selects the sweep. 0 steps down by 1 per tick, 1 steps up, and 2 steps up to the upper bound and then restarts at the start tap stepping down. In a searching mode, 3 keeps the tap at the start tap.
- R5: The first pass of a sweep stays within [G, 432-G], where G is `cfg_guard`. If that pass finds nothing, a second pass from the start tap covers [0, 432].
- R6: Let e = phase minus target, both signed 5-bit. With `cfg_exact`=1, a tap is accepted only when e = 0. With `cfg_exact`=0, it is accepted when |e| <= 2.
- R7: When both passes fail and `cfg_fail_rst`=1, the tap returns to the start tap and stays there until `cfg_en` drops. With 0, the sweep restarts at the first pass.
- R8: While tracking with e not accepted, `cfg_slope`=0 (negative detector slope) moves the tap up when e > 0 and down when e < 0. `cfg_slope`=1 reverses this.
- R9: A tracking move is 1 tap when `cfg_gain`=0 and 2 taps when `cfg_gain`=1, clamped to [0, 432].
- R10: `locked` rises on the tick that accepts the phase. If a later tick in track or hold finds the phase unaccepted, `locked` falls and `lost_lock` is set. `lost_lock` stays set until disable or reset.
- R11: `rb_tap` and `rb_phase` load the tap and phase on the clock where `rd_req` is sampled 0 after being sampled 1. At all other times they hold their value.
- R12: `tap_out` never exceeds 432.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Controller enable |
| cfg_gain | input | 1 | Tracking step: 0 moves 1 tap, 1 moves 2 taps |
| cfg_target | input | 5 | Target phase, signed |
| cfg_slope | input | 1 | Detector slope: 0 is negative, 1 is positive |
| cfg_start | input | 9 | Start tap |
| cfg_mode | input | 2 | Operating mode |
| cfg_dir | input | 2 | Sweep direction |
| cfg_guard | input | 5 | Guard-band width at each end of the line |
| cfg_exact | input | 1 | Match rule: 1 exact, 0 within 2 |
| cfg_fail_rst | input | 1 | On failure: 1 halt at the start tap, 0 keep searching |
| cfg_manual | input | 9 | Tap used while disabled |
| rd_req | input | 1 | Readback request, takes effect on its falling edge |
| ph_meas | input | 5 | Phase detector reading, signed |
| tap_out | output | 9 | Delay tap select |
| locked | output | 1 | Lock achieved |
| lost_lock | output | 1 | Sticky loss-of-lock flag |
| rb_tap | output | 9 | Latched tap |
| rb_phase | output | 5 | Latched phase |

## Verification
Every result is one register away from its cause. The tap, `locked` and `lost_lock` change on the clock edge that samples the tick or the enable level. The readback fields change on the edge that sees `rd_req` low after high. The bench drives inputs on falling edges and replays the same edge in a behavioural model that keeps its own tick counter. It compares all five outputs on the following falling edge, so each expected value is due exactly one edge after the stimulus that caused it. The phase input comes from a delay-line model fed by the design's own tap output. Directed checks at scenario ends confirm the lock taps, worked out by hand for the exact, tolerant, guard-band, two-leg and clamped cases.

// File: rtl/phs_pkg.sv
package phs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SEARCH = 3'd1,
    ST_TRACK  = 3'd2,
    ST_HOLD   = 3'd3,
    ST_HALT   = 3'd4
  } phs_state_e;

  localparam logic [1:0] MODE_TRACK = 2'd1;
  localparam logic [1:0] MODE_SRCH  = 2'd2;
  localparam logic [1:0] MODE_BAD   = 2'd3;
  localparam logic [1:0] DIR_DOWN   = 2'd0;
  localparam logic [1:0] DIR_BOTH   = 2'd2;
  localparam logic [1:0] DIR_BAD    = 2'd3;

  // Signed phase error (measured minus wanted)
  function automatic int phase_err(int meas, int tgt);
    return meas - tgt;
  endfunction

  // Acceptance rule for a phase error
  function automatic logic err_ok(int e, logic exact);
    int mag;
    mag = (e < 0) ? -e : e;
    return exact ? (mag == 0) : (mag <= 2);
  endfunction

  // Move t by d, kept inside [0, hi]
  function automatic int bounded_step(int t, int d, int hi);
    int v;
    v = t + d;
    if (v < 0) v = 0;
    if (v > hi) v = hi;
    return v;
  endfunction

endpackage

// File: rtl/phs_tick_gen.sv
module phs_tick_gen #(
  parameter int EVAL_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (EVAL_CYC > 2) ? $clog2(EVAL_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(EVAL_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  // R2: ticks are spaced, never back to back
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick) else $error("tick repeated");

endmodule

// File: rtl/phs_judge.sv
module phs_judge #(
  parameter int PH_W = 5
) (
  input  logic [PH_W-1:0] meas,
  input  logic [PH_W-1:0] target,
  input  logic            slope,
  input  logic            exact,
  output logic            match,
  output logic            want_up
);
  import phs_pkg::*;

  int e;

  always_comb begin
    e       = phase_err(int'($signed(meas)), int'($signed(target)));
    match   = err_ok(e, exact);
    // negative slope: raising the tap lowers the phase
    want_up = slope ? (e < 0) : (e > 0);
  end

endmodule

// File: rtl/phs_readback.sv
module phs_readback #(
  parameter int TAP_W = 9,
  parameter int PH_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [TAP_W-1:0] tap,
  input  logic [PH_W-1:0]  ph,
  output logic [TAP_W-1:0] rb_tap,
  output logic [PH_W-1:0]  rb_ph
);
  logic rd_q;
  logic cap_evt;

  assign cap_evt = rd_q && !rd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      rb_tap <= '0;
      rb_ph  <= '0;
    end else begin
      rd_q <= rd_req;
      if (cap_evt) begin
        rb_tap <= tap;
        rb_ph  <= ph;
      end
    end
  end

  assert_rb_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> ($stable(rb_tap) && $stable(rb_ph))) else $error("readback moved");

endmodule

// File: rtl/phs_search_ctrl.sv
module phs_search_ctrl #(
  parameter int TAP_W    = 9,
  parameter int TAP_MAX  = 432,
  parameter int PH_W     = 5,
  parameter int GB_W     = 5,
  parameter int EVAL_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_gain,
  input  logic [PH_W-1:0]  cfg_target,
  input  logic             cfg_slope,
  input  logic [TAP_W-1:0] cfg_start,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_dir,
  input  logic [GB_W-1:0]  cfg_guard,
  input  logic             cfg_exact,
  input  logic             cfg_fail_rst,
  input  logic [TAP_W-1:0] cfg_manual,
  input  logic             rd_req,
  input  logic [PH_W-1:0]  ph_meas,
  output logic [TAP_W-1:0] tap_out,
  output logic             locked,
  output logic             lost_lock,
  output logic [TAP_W-1:0] rb_tap,
  output logic [PH_W-1:0]  rb_phase
);
  import phs_pkg::*;

  localparam logic [TAP_W-1:0] MAX_T = TAP_W'(TAP_MAX);

  phs_state_e       st_q, st_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic             pass_q, pass_d;
  logic             up_q, up_d;
  logic             lk_q, lk_d;
  logic             lost_q, lost_d;

  logic             tick, match, want_up, run;
  logic             cfg_ok;
  logic [TAP_W-1:0] start_c, man_c, lo_b, hi_b, trk_tap;
  logic             can_up, can_dn;
  // named events for the checks
  logic             leg_turn, pass_over, sweep_fail;

  assign run     = (st_q == ST_SEARCH) || (st_q == ST_TRACK) || (st_q == ST_HOLD);
  assign start_c = (cfg_start  > MAX_T) ? MAX_T : cfg_start;
  assign man_c   = (cfg_manual > MAX_T) ? MAX_T : cfg_manual;
  assign cfg_ok  = (cfg_mode != MODE_BAD) && ((cfg_mode == MODE_TRACK) || (cfg_dir != DIR_BAD));
  assign lo_b    = pass_q ? '0 : TAP_W'(cfg_guard);
  assign hi_b    = pass_q ? MAX_T : (MAX_T - TAP_W'(cfg_guard));
  assign can_up  = tap_q < hi_b;
  assign can_dn  = tap_q > lo_b;
  assign trk_tap = TAP_W'(bounded_step(int'(tap_q),
                     (want_up ? 1 : -1) * (cfg_gain ? 2 : 1), TAP_MAX));

  phs_tick_gen #(.EVAL_CYC(EVAL_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick));

  phs_judge #(.PH_W(PH_W)) u_judge (
    .meas(ph_meas), .target(cfg_target), .slope(cfg_slope),
    .exact(cfg_exact), .match(match), .want_up(want_up));

  phs_readback #(.TAP_W(TAP_W), .PH_W(PH_W)) u_rb (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .tap(tap_q), .ph(ph_meas),
    .rb_tap(rb_tap), .rb_ph(rb_phase));

  always_comb begin
    st_d = st_q; tap_d = tap_q; pass_d = pass_q; up_d = up_q;
    lk_d = lk_q; lost_d = lost_q;
    leg_turn = 1'b0; pass_over = 1'b0; sweep_fail = 1'b0;
    if (!cfg_en) begin
      st_d = ST_IDLE; tap_d = man_c; lk_d = 1'b0; lost_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          tap_d = start_c;
          if (cfg_ok) begin
            st_d   = (cfg_mode == MODE_TRACK) ? ST_TRACK : ST_SEARCH;
            pass_d = 1'b0;
            up_d   = (cfg_dir != DIR_DOWN);
          end
        end
        ST_SEARCH: if (tick) begin
          if (match) begin
            lk_d = 1'b1;
            st_d = (cfg_mode == MODE_SRCH) ? ST_HOLD : ST_TRACK;
          end else if (up_q && can_up) begin
            tap_d = tap_q + TAP_W'(1);
          end else if (!up_q && can_dn) begin
            tap_d = tap_q - TAP_W'(1);
          end else if (up_q && (cfg_dir == DIR_BOTH)) begin
            leg_turn = 1'b1; up_d = 1'b0; tap_d = start_c;
          end else if (!pass_q) begin
            pass_over = 1'b1; pass_d = 1'b1; tap_d = start_c;
            up_d = (cfg_dir != DIR_DOWN);
          end else if (cfg_fail_rst) begin
            sweep_fail = 1'b1; st_d = ST_HALT; tap_d = start_c;
          end else begin
            sweep_fail = 1'b1; pass_d = 1'b0; tap_d = start_c;
            up_d = (cfg_dir != DIR_DOWN);
          end
        end
        ST_TRACK: if (tick) begin
          if (match) lk_d = 1'b1;
          else begin
            if (lk_q) begin lk_d = 1'b0; lost_d = 1'b1; end
            tap_d = trk_tap;
          end
        end
        ST_HOLD: if (tick) begin
          if (match) lk_d = 1'b1;
          else if (lk_q) begin lk_d = 1'b0; lost_d = 1'b1; end
        end
        ST_HALT: ;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; tap_q <= '0; pass_q <= 1'b0; up_q <= 1'b0;
      lk_q <= 1'b0; lost_q <= 1'b0;
    end else begin
      st_q <= st_d; tap_q <= tap_d; pass_q <= pass_d; up_q <= up_d;
      lk_q <= lk_d; lost_q <= lost_d;
    end
  end

  assign tap_out   = tap_q;
  assign locked    = lk_q;
  assign lost_lock = lost_q;

  assert_tap_limit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tap_q <= MAX_T) else $error("tap above limit");

  assert_move_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && cfg_en) |=> $stable(tap_q)) else $error("tap moved off tick");

  assert_lock_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lk_q) |-> $past(tick && match && cfg_en)) else $error("lock without match");

  assert_lost_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_q && cfg_en) |=> lost_q) else $error("lost flag dropped");

  assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT && cfg_en) |=> (st_q == ST_HALT && $stable(tap_q)))
    else $error("halt left");

  assert_track_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRACK && tick && cfg_en) |=>
      (((tap_q > $past(tap_q)) ? (tap_q - $past(tap_q)) : ($past(tap_q) - tap_q)) <= TAP_W'(2)))
    else $error("track step too large");

  assert_restart_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_turn || pass_over) |=> (tap_q == $past(start_c))) else $error("pass restart");

endmodule

// File: tb/phs_search_ctrl_tb.sv
module phs_search_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 0, cfg_gain = 0, cfg_slope = 0, cfg_exact = 1, cfg_fail_rst = 0, rd_req = 0;
  logic [4:0] cfg_target = 0, cfg_guard = 0;
  logic [8:0] cfg_start = 0, cfg_manual = 0;
  logic [1:0] cfg_mode = 0, cfg_dir = 0;
  logic [4:0] ph_meas;
  logic [8:0] tap_out, rb_tap;
  logic       locked, lost_lock;
  logic [4:0] rb_phase;

  int vec = 0, bad = 0, cyc = 0;
  int ctr = 200;          // delay-line model: phase zero crossing tap
  bit neg = 1'b1;         // delay-line model slope
  string cur = "R1";

  always #10 clk = ~clk;  // 50 MHz

  function automatic int phase_calc(int t, int c, bit n);
    int d, p;
    d = c - t;
    p = (d >= 0) ? d / 4 : -((-d + 3) / 4);
    if (!n) p = -p;
    if (p > 15) p = 15;
    if (p < -16) p = -16;
    return p;
  endfunction

  assign ph_meas = 5'(phase_calc(int'(tap_out), ctr, neg));

  phs_search_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_gain(cfg_gain),
    .cfg_target(cfg_target), .cfg_slope(cfg_slope), .cfg_start(cfg_start),
    .cfg_mode(cfg_mode), .cfg_dir(cfg_dir), .cfg_guard(cfg_guard),
    .cfg_exact(cfg_exact), .cfg_fail_rst(cfg_fail_rst), .cfg_manual(cfg_manual),
    .rd_req(rd_req), .ph_meas(ph_meas), .tap_out(tap_out), .locked(locked),
    .lost_lock(lost_lock), .rb_tap(rb_tap), .rb_phase(rb_phase));

  // behavioural reference: 0 idle, 1 search, 2 track, 3 hold, 4 halt
  int m_st, m_tap, m_cnt, m_pass, m_up, m_lk, m_lost, m_rd, m_rbt, m_rbp;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_tap = 0; m_cnt = 0; m_pass = 0; m_up = 0;
      m_lk = 0; m_lost = 0; m_rd = 0; m_rbt = 0; m_rbp = 0;
    end else begin
      int ot, ph, e, lo, hi, st0, sc;
      bit act, tk, ok, go_up;
      ot = m_tap; st0 = m_st;
      ph = phase_calc(ot, ctr, neg);
      e = ph - $signed(cfg_target);
      ok = cfg_exact ? (e == 0) : (e >= -2 && e <= 2);
      act = (st0 >= 1 && st0 <= 3);
      tk = act && (m_cnt == 3);
      m_cnt = act ? (tk ? 0 : m_cnt + 1) : 0;
      if (m_rd && !rd_req) begin m_rbt = ot; m_rbp = ph; end
      m_rd = rd_req;
      sc = (cfg_start > 432) ? 432 : int'(cfg_start);
      if (!cfg_en) begin
        m_st = 0; m_tap = (cfg_manual > 432) ? 432 : int'(cfg_manual); m_lk = 0; m_lost = 0;
      end else if (st0 == 0) begin
        m_tap = sc;
        if (cfg_mode != 3 && (cfg_mode == 1 || cfg_dir != 3)) begin
          m_st = (cfg_mode == 1) ? 2 : 1; m_pass = 0; m_up = (cfg_dir != 0);
        end
      end else if (tk && st0 == 1) begin
        lo = m_pass ? 0 : cfg_guard; hi = m_pass ? 432 : 432 - cfg_guard;
        if (ok) begin m_lk = 1; m_st = (cfg_mode == 2) ? 3 : 2; end
        else if (m_up && ot < hi) m_tap = ot + 1;
        else if (!m_up && ot > lo) m_tap = ot - 1;
        else if (m_up && cfg_dir == 2) begin m_up = 0; m_tap = sc; end
        else if (!m_pass) begin m_pass = 1; m_tap = sc; m_up = (cfg_dir != 0); end
        else if (cfg_fail_rst) begin m_st = 4; m_tap = sc; end
        else begin m_pass = 0; m_tap = sc; m_up = (cfg_dir != 0); end
      end else if (tk && st0 == 2) begin
        if (ok) m_lk = 1;
        else begin
          if (m_lk) begin m_lk = 0; m_lost = 1; end
          go_up = cfg_slope ? (e < 0) : (e > 0);
          m_tap = go_up ? ot + (cfg_gain ? 2 : 1) : ot - (cfg_gain ? 2 : 1);
          if (m_tap > 432) m_tap = 432;
          if (m_tap < 0) m_tap = 0;
        end
      end else if (tk && st0 == 3) begin
        if (ok) m_lk = 1;
        else if (m_lk) begin m_lk = 0; m_lost = 1; end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the reference, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk(cur, "tap_out", int'(tap_out), m_tap);
    chk(cur, "locked", int'(locked), m_lk);
    chk(cur, "lost_lock", int'(lost_lock), m_lost);
    chk(cur, "rb_tap", int'(rb_tap), m_rbt);
    chk(cur, "rb_phase", int'($signed(rb_phase)), m_rbp);
  end

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        bad++;
        $display("FAIL watchdog %s actual=%0d expected=<150000 cycles", cur, cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(int mode, int dir, int start, int guard, int tgt,
                       bit exact, bit fail, bit slope, bit gain, int c, bit n);
    cfg_en = 0; run(3);
    cfg_mode = 2'(mode); cfg_dir = 2'(dir); cfg_start = 9'(start);
    cfg_guard = 5'(guard); cfg_target = 5'(tgt); cfg_exact = exact;
    cfg_fail_rst = fail; cfg_slope = slope; cfg_gain = gain; ctr = c; neg = n;
    run(1); cfg_en = 1;
  endtask

  initial begin
    int t0;
    run(3);
    // R1 reset state
    chk("R1", "reset tap", int'(tap_out), 0);
    chk("R1", "reset locked", int'(locked), 0);
    chk("R1", "reset rb_tap", int'(rb_tap), 0);
    rst_n = 1;
    cur = "R1"; cfg_manual = 9'd500; run(2);
    chk("R1", "manual clamp", int'(tap_out), 432);
    cfg_manual = 9'd100; run(2);
    chk("R1", "manual follow", int'(tap_out), 100);
    chk("R1", "lost while off", int'(lost_lock), 0);

    // R3 search only, up sweep: lock at 221 and freeze; R2 tick spacing via model
    cur = "R3";
    setup(2, 1, 220, 11, -6, 1, 0, 0, 0, 200, 1);
    run(1); chk("R2", "start tap", int'(tap_out), 220);
    run(100);
    chk("R3", "search-only lock tap", int'(tap_out), 221);
    chk("R3", "search-only locked", int'(locked), 1);

    // R4 down sweep
    cur = "R4";
    setup(2, 0, 220, 11, -6, 1, 0, 0, 0, 150, 1);
    run(300);
    chk("R4", "down sweep tap", int'(tap_out), 174);
    // R4 up then down from start
    setup(2, 2, 220, 11, -6, 1, 0, 0, 0, 150, 1);
    run(1200);
    chk("R4", "two-leg tap", int'(tap_out), 174);
    chk("R4", "two-leg locked", int'(locked), 1);

    // R5 guard band: only taps 1..4 match, reached on the second pass
    cur = "R5";
    setup(2, 0, 220, 11, -6, 1, 0, 0, 0, -20, 1);
    run(2000);
    chk("R5", "guard-zone tap", int'(tap_out), 4);
    chk("R5", "guard-zone locked", int'(locked), 1);

    // R7 failure handling
    cur = "R7";
    setup(2, 1, 220, 11, 10, 1, 1, 0, 0, -20, 1);
    run(2000);
    chk("R7", "halt tap", int'(tap_out), 220);
    chk("R7", "halt unlocked", int'(locked), 0);
    setup(2, 1, 220, 11, 10, 1, 0, 0, 0, -20, 1);
    run(2000);
    t0 = int'(tap_out); run(8);
    chk("R7", "continue keeps moving", int'(tap_out != 9'(t0)), 1);

    // R8/R9 track only, negative slope, gain 1 tap
    cur = "R8";
    setup(1, 3, 220, 0, -6, 1, 0, 0, 0, 300, 1);
    run(500);
    chk("R8", "track lock tap", int'(tap_out), 321);
    chk("R9", "track locked", int'(locked), 1);
    // R11 readback pulse
    cur = "R11";
    rd_req = 1; run(2); rd_req = 0; run(2);
    chk("R11", "rb_tap", int'(rb_tap), 321);
    chk("R11", "rb_phase", int'($signed(rb_phase)), -6);
    // R10 drift: loses lock, retracks, flag sticks
    cur = "R10";
    ctr = 310; run(8);
    chk("R10", "lost set", int'(lost_lock), 1);
    run(200);
    chk("R10", "relocked", int'(locked), 1);
    chk("R10", "lost sticky", int'(lost_lock), 1);
    chk("R10", "retrack tap", int'(tap_out), 331);

    // R6 tolerant match in search-then-track
    cur = "R6";
    setup(0, 1, 200, 11, -6, 0, 0, 0, 0, 200, 1);
    run(200);
    chk("R6", "tolerant tap", int'(tap_out), 213);
    chk("R6", "tolerant locked", int'(locked), 1);

    // R8/R9 positive slope, 2-tap steps
    cur = "R9";
    setup(1, 0, 220, 0, -6, 1, 0, 1, 1, 300, 0);
    run(200);
    chk("R9", "gain-2 lock tap", int'(tap_out), 274);
    chk("R8", "positive slope locked", int'(locked), 1);

    // R12 clamp at the top of the line; R11 hold while rd_req stays high
    cur = "R12";
    rd_req = 1;
    setup(1, 0, 400, 0, -6, 1, 0, 0, 1, 700, 1);
    run(200);
    chk("R12", "clamped tap", int'(tap_out), 432);
    chk("R11", "rb held", int'(rb_tap), 321);
    rd_req = 0;

    // R3/R4 invalid codes
    cur = "R3";
    setup(3, 1, 250, 0, -6, 1, 0, 0, 0, 200, 1);
    run(100);
    chk("R3", "invalid mode tap", int'(tap_out), 250);
    chk("R3", "invalid mode unlocked", int'(locked), 0);
    cur = "R4";
    setup(0, 3, 260, 0, -6, 1, 0, 0, 0, 200, 1);
    run(100);
    chk("R4", "invalid dir tap", int'(tap_out), 260);

    cfg_en = 0; run(3);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule